// File: doc/BRIEF.md
# Key Wake-up Interrupt Controller

This block watches two groups of input lines and raises one level interrupt request when a watched line shows a wake-up event. Group G has seven event lines (0..6) plus a clock-qualifier line (7). Group H has eight event lines. Every line passes through a two-stage synchronizer. Events are detected from the synchronized level. Each event sets a sticky flag. The interrupt output is the OR of all flags whose enable bit is set.

A single-cycle register bus reaches four byte registers. The group G control register holds the group G enables and a mode bit. The group H enable register holds the group H enables. Two flag registers are cleared by writing ones. The mode bit turns group G line 6 from a plain falling-edge input into a detector for the I2C START condition: line 6 acts as SDA and line 7 as SCL. The mode bit also goes out as a status signal, so the pad logic can run lines 6 and 7 open-drain.

Top module: `kwu_irq_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), all four registers read 0x00, irq_req is low and g_open_drain is low.
- R2: The group G control register at offset 0x2C holds the mode bit in bit 7 and the enables for group G lines 6..0 in bits 6..0. The group H enable register at 0x2D holds the enables for group H lines 7..0 in bits 7..0. Both are written with bus_sel=1 and bus_wr=1 and read back unchanged with bus_sel=1 and bus_wr=0.
- R3: A high-to-low change on group G lines 5..0 or group H lines 7..0 sets the flag with the same bit index. A low-to-high change sets no flag. A flag is set whether or not its line is enabled.
- R4: Group G flags read at 0x2E and group H flags at 0x2F. Bit 7 at 0x2E always reads 0. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged.
- R5: irq_req is high exactly when some flag and its enable bit are both 1. The mode bit never counts as an enable.
- R6: With the mode bit at 0, a falling edge on group G line 6 sets flag 6 at any level of line 7.
- R7: With the mode bit at 1, a falling edge on group G line 6 sets flag 6 only when the synchronized line 7 is high in the same cycle. A fall of line 7 alone sets no flag.
- R8: g_open_drain equals the mode bit.
- R9: If an event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R10: A pin change made between clock edges shows in its flag register after the third rising edge that follows the change, and not after the second.
- R11: Writes to any offset other than 0x2C..0x2F change no register. Reads at unmapped offsets, and reads with bus_sel=0, return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (when bus_sel = 1) |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_g | input | 8 | Group G lines (bit 6 = SDA, bit 7 = SCL in START mode) |
| pin_h | input | 8 | Group H lines |
| irq_req | output | 1 | Combined wake-up interrupt request |
| g_open_drain | output | 1 | Open-drain request for group G lines 6 and 7 |

## Verification
The hardest case to reach is a clearing write that lands in the very cycle in which the synchronized falling edge for the same bit is present. The bench changes a pin just after a falling clock edge. It then counts exactly two rising edges through the synchronizer and edge register, and issues the write so that it commits on the third. The same edge counting gives the latency check. START-mode behaviour is driven from the vector table with SDA falling either under a steady-high SCL or together with SCL. The second case must give no event, because the synchronized SCL is already low when the SDA fall is seen.

// File: rtl/kwu_pkg.sv
// Package: shared widths, register offsets and line roles for the key
// wake-up controller. Assumes byte-wide registers on an 8-bit offset bus.
package kwu_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int SDA_IDX     = 6;
    localparam int SCL_IDX     = 7;

    localparam logic [ADDR_W-1:0] OFS_CTL_G  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_EN_H   = 8'h2D;
    localparam logic [ADDR_W-1:0] OFS_FLAG_G = 8'h2E;
    localparam logic [ADDR_W-1:0] OFS_FLAG_H = 8'h2F;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTL_G,
        REG_EN_H,
        REG_FLAG_G,
        REG_FLAG_H
    } reg_sel_e;

    // Map an offset to the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_CTL_G:  return REG_CTL_G;
            OFS_EN_H:   return REG_EN_H;
            OFS_FLAG_G: return REG_FLAG_G;
            OFS_FLAG_H: return REG_FLAG_H;
            default:    return REG_NONE;
        endcase
    endfunction
endpackage

// File: rtl/kwu_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous lines.
// Assumes the lines idle high, so every stage resets to all ones and a
// line that is high at reset release produces no false falling edge.
module kwu_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the sampled lines through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/kwu_edge_det.sv
// Module: per-line falling-edge detector working on synchronized levels.
// With START_EN set, line SDA can instead report an I2C START (SDA falls
// while SCL is high), and line SCL never reports an event itself.
// Assumes lvl is already synchronous to clk and idles high.
module kwu_edge_det #(
    parameter int W        = 8,
    parameter bit START_EN = 1'b0,
    parameter int SDA      = 6,
    parameter int SCL      = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         start_mode,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_line
        if (START_EN && i == SCL) begin : g_qual
            // The SCL line only qualifies the SDA line; it raises no event.
            assign evt[i] = 1'b0;
        end else begin : g_det
            logic prev_q;
            logic fall;

            // Hold last cycle's level for edge comparison.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b1;
                else        prev_q <= lvl[i];
            end

            assign fall = prev_q & ~lvl[i];

            if (START_EN && i == SDA) begin : g_start
                // Pick the plain edge or the SCL-qualified START.
                always_comb begin
                    if (start_mode) evt[i] = fall & lvl[SCL];
                    else            evt[i] = fall;
                end

                AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
                    (start_mode && evt[i]) |-> (lvl[SCL] && $past(lvl[i]) && !lvl[i])); // R7
                AST_PLAIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
                    (!start_mode && $fell(lvl[i])) |-> evt[i]); // R6
            end else begin : g_plain
                assign evt[i] = fall;
            end
        end
    end
endmodule

// File: rtl/kwu_flag_bank.sv
// Module: bank of sticky event flags, cleared by a write-one mask.
// Assumes evt and clr are single-cycle pulses; an event outranks a clear.
module kwu_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_q;

    // Clear the selected bits, then let new events set theirs.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | evt;
    end

    assign flags = flags_q;

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt))); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((flags_q & $past(clr & ~evt)) == '0)); // R4
    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(evt)) == '0)); // R3
endmodule

// File: rtl/kwu_irq_ctrl.sv
// Module: key wake-up interrupt controller top. Holds the enable and mode
// registers, decodes the register bus, synchronizes both line groups,
// detects events, keeps flags and forms the combined interrupt request.
// Assumes a single-cycle bus: a write commits at the rising edge where
// bus_sel and bus_wr are high; reads are combinational.
module kwu_irq_ctrl
    import kwu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_g,
    input  logic [DATA_W-1:0] pin_h,
    output logic              irq_req,
    output logic              g_open_drain
);
    localparam logic [DATA_W-1:0] G_EVT_MASK = ~(DATA_W'(1) << SCL_IDX);

    reg_sel_e          sel;
    logic              wr_en;
    logic [DATA_W-1:0] ctl_g_q, en_h_q;
    logic [DATA_W-1:0] sync_g, sync_h;
    logic [DATA_W-1:0] evt_g, evt_h;
    logic [DATA_W-1:0] clr_g, clr_h;
    logic [DATA_W-1:0] flag_g, flag_h;
    logic [DATA_W-1:0] en_g_eff;
    logic              start_mode;

    assign sel        = decode_ofs(bus_addr);
    assign wr_en      = bus_sel & bus_wr;
    assign start_mode = ctl_g_q[SCL_IDX];
    assign en_g_eff   = ctl_g_q & G_EVT_MASK;

    // Update the enable and mode registers on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_g_q <= '0;
            en_h_q  <= '0;
        end else if (wr_en) begin
            if (sel == REG_CTL_G) ctl_g_q <= bus_wdata;
            if (sel == REG_EN_H)  en_h_q  <= bus_wdata;
        end
    end

    // Form the write-one clear masks for both flag banks.
    always_comb begin
        clr_g = '0;
        clr_h = '0;
        if (wr_en && sel == REG_FLAG_G) clr_g = bus_wdata;
        if (wr_en && sel == REG_FLAG_H) clr_h = bus_wdata;
    end

    // Return the addressed register on a read.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                REG_CTL_G:  bus_rdata = ctl_g_q;
                REG_EN_H:   bus_rdata = en_h_q;
                REG_FLAG_G: bus_rdata = flag_g;
                REG_FLAG_H: bus_rdata = flag_h;
                default:    bus_rdata = '0;
            endcase
        end
    end

    kwu_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_g (
        .clk(clk), .rst_n(rst_n), .din(pin_g), .dout(sync_g));
    kwu_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_h (
        .clk(clk), .rst_n(rst_n), .din(pin_h), .dout(sync_h));

    kwu_edge_det #(.W(DATA_W), .START_EN(1'b1), .SDA(SDA_IDX), .SCL(SCL_IDX)) u_det_g (
        .clk(clk), .rst_n(rst_n), .lvl(sync_g), .start_mode(start_mode), .evt(evt_g));
    kwu_edge_det #(.W(DATA_W), .START_EN(1'b0), .SDA(SDA_IDX), .SCL(SCL_IDX)) u_det_h (
        .clk(clk), .rst_n(rst_n), .lvl(sync_h), .start_mode(1'b0), .evt(evt_h));

    kwu_flag_bank #(.W(DATA_W)) u_flags_g (
        .clk(clk), .rst_n(rst_n), .evt(evt_g), .clr(clr_g), .flags(flag_g));
    kwu_flag_bank #(.W(DATA_W)) u_flags_h (
        .clk(clk), .rst_n(rst_n), .evt(evt_h), .clr(clr_h), .flags(flag_h));

    assign irq_req      = (|(flag_g & en_g_eff)) | (|(flag_h & en_h_q));
    assign g_open_drain = start_mode;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|(ctl_g_q & G_EVT_MASK) || |en_h_q)); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctl_g_q) && $stable(en_h_q))); // R11
    AST_SCL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_g[SCL_IDX]); // R4
endmodule

// File: tb/kwu_irq_ctrl_test.sv
// Bench: table of pin patterns with expected flags, then directed tests.
module kwu_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_g = 8'hFF;
    logic [7:0] pin_h = 8'hFF;
    logic       irq_req;
    logic       g_open_drain;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    kwu_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_g(pin_g), .pin_h(pin_h), .irq_req(irq_req), .g_open_drain(g_open_drain));

    // {mode, pin_g pattern, pin_h pattern, expected G flags, expected H flags}
    localparam int NV = 9;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'hFE, 8'hFF, 8'h01, 8'h00},
        {1'b0, 8'hFF, 8'h7F, 8'h00, 8'h80},
        {1'b0, 8'hC0, 8'h00, 8'h3F, 8'hFF},
        {1'b0, 8'h3F, 8'hFF, 8'h40, 8'h00},
        {1'b1, 8'hBF, 8'hFF, 8'h40, 8'h00},
        {1'b1, 8'h3F, 8'hFF, 8'h00, 8'h00},
        {1'b1, 8'h7F, 8'hFF, 8'h00, 8'h00},
        {1'b1, 8'hAA, 8'h55, 8'h55, 8'hAA},
        {1'b0, 8'h7F, 8'hFF, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Caller sits just after a falling edge; the write commits at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h2C, d); chk("R1 ctl_g", d, 8'h00);
        rd(8'h2D, d); chk("R1 en_h", d, 8'h00);
        rd(8'h2E, d); chk("R1 flag_g", d, 8'h00);
        rd(8'h2F, d); chk("R1 flag_h", d, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        chk("R1 od", {7'd0, g_open_drain}, 8'h00);

        // R2 / R8: register access and mode output
        wr(8'h2C, 8'hA5); rd(8'h2C, d); chk("R2 ctl_g", d, 8'hA5);
        chk("R8 od set", {7'd0, g_open_drain}, 8'h01);
        wr(8'h2C, 8'h25); chk("R8 od clear", {7'd0, g_open_drain}, 8'h00);
        wr(8'h2D, 8'h3C); rd(8'h2D, d); chk("R2 en_h", d, 8'h3C);

        // R11: unmapped offsets and unselected reads
        wr(8'h30, 8'hFF); wr(8'h2B, 8'hFF);
        rd(8'h2C, d); chk("R11 ctl_g kept", d, 8'h25);
        rd(8'h2D, d); chk("R11 en_h kept", d, 8'h3C);
        rd(8'h30, d); chk("R11 unmapped read", d, 8'h00);
        bus_addr = 8'h2D; #1 chk("R11 no sel", bus_rdata, 8'h00);

        // R3 R6 R7 R4 R5: vector table
        for (int v = 0; v < NV; v++) begin
            logic [7:0] eg, eh;
            eg = VEC[v][15:8];
            eh = VEC[v][7:0];
            pin_g = 8'hFF; pin_h = 8'hFF;
            wr(8'h2C, {VEC[v][32], 7'h7F});
            wr(8'h2D, 8'hFF);
            idle(4);
            wr(8'h2E, 8'hFF); wr(8'h2F, 8'hFF);
            pin_g = VEC[v][31:24]; pin_h = VEC[v][23:16];
            idle(4);
            rd(8'h2E, d); chk($sformatf("R3/R6/R7 vec%0d flag_g", v), d, eg);
            rd(8'h2F, d); chk($sformatf("R3 vec%0d flag_h", v), d, eh);
            chk($sformatf("R5 vec%0d irq", v), {7'd0, irq_req}, {7'd0, |(eg | eh)});
            pin_g = 8'hFF; pin_h = 8'hFF;
            idle(4);
            rd(8'h2E, d); chk($sformatf("R3 vec%0d rise g", v), d, eg);
            rd(8'h2F, d); chk($sformatf("R3 vec%0d rise h", v), d, eh);
        end

        // R5: enable gating, flag set while disabled
        wr(8'h2C, 8'h80); wr(8'h2D, 8'h00);
        wr(8'h2E, 8'hFF); wr(8'h2F, 8'hFF);
        pin_h = 8'hFD; idle(4);
        rd(8'h2F, d); chk("R3 flag while disabled", d, 8'h02);
        chk("R5 irq masked, mode bit no enable", {7'd0, irq_req}, 8'h00);
        wr(8'h2D, 8'h01); chk("R5 other enable", {7'd0, irq_req}, 8'h00);
        wr(8'h2D, 8'h02); chk("R5 matching enable", {7'd0, irq_req}, 8'h01);

        // R4: write-one clear
        pin_h = 8'hFC; idle(4);
        wr(8'h2F, 8'h00); rd(8'h2F, d); chk("R4 write zero", d, 8'h03);
        wr(8'h2F, 8'h01); rd(8'h2F, d); chk("R4 clear one bit", d, 8'h02);
        wr(8'h2F, 8'hFF); rd(8'h2F, d); chk("R4 clear all", d, 8'h00);
        chk("R5 irq drops", {7'd0, irq_req}, 8'h00);
        pin_h = 8'hFF; idle(4);

        // R10: latency through synchronizer and edge register
        pin_h = 8'hFE;
        idle(2); rd(8'h2F, d); chk("R10 after two edges", d, 8'h00);
        idle(1); rd(8'h2F, d); chk("R10 after three edges", d, 8'h01);
        wr(8'h2F, 8'hFF); pin_h = 8'hFF; idle(4);

        // R9: clear committing on the same edge as the event
        pin_h = 8'hFB;
        idle(2);
        wr(8'h2F, 8'h04);
        rd(8'h2F, d); chk("R9 event beats clear", d, 8'h04);
        wr(8'h2F, 8'h04); rd(8'h2F, d); chk("R9 later clear", d, 8'h00);

        summary();
    end
endmodule